// File: doc/BRIEF.md
# Packet Receive Buffer Controller

This block sits between a packet radio demodulator and a host register port. The demodulator drives strobes for start of packet, received byte (with a per-byte quality flag), end of packet and receive error. The block stores the bytes in a 16-entry byte buffer. The host drains the buffer through a data port. Bytes are accepted only after the host has armed receive mode and a start of packet has been taken. A packet closes on an end-of-packet or an error strobe, and that also ends receive mode.

Two configuration choices decide what the buffer holds. The overwrite choice is made when a start of packet arrives: with it, an unread packet is thrown away and replaced. Without it, the new packet is refused until the host has drained the old one. The valid-flag mode cuts data capacity to half the buffer and uses the other half to store each byte's quality flag, which the host reads from its own address window. A fast-turn low-side setting inverts every received bit before it is stored. Live and sticky status bits, each gated by an enable, are combined into one interrupt line.

Top module: `rxbuf_ctrl`

## Requirements
- R1: After reset the control register (address 0x00) reads 0x07, the configuration register (address 0x01) reads 0x10, the count (address 0x03) reads 0, the status register (address 0x02) reads 0x10 and `irq_o` is 0.
- R2: Writing the control register with bit 7 set enters receive mode, and bit 7 then reads 1. It clears by itself on the cycle after a packet closes. Writing bit 7 as 0 leaves receive mode unchanged. Bits 6..0 are plain read/write interrupt enables.
- R3: A start of packet is taken only in receive mode while no packet is open. Bytes are stored only while a packet is open. An end-of-packet strobe or an error strobe closes the open packet. Strobes that arrive while no packet is open are ignored.
- R4: A host read of address 0x04 returns the oldest unread byte on `host_rdata_o` one clock later and lowers the count by one. A read while the count is 0 returns 0x00 and sets the buffer-error status.
- R5: Capacity is 16 bytes per packet (8 in valid-flag mode). A byte received after capacity bytes of the current packet is dropped and sets the buffer-error status.
- R6: With overwrite enable (configuration bit 1) at 0, a start of packet that arrives while the count is non-zero is ignored, and the stored bytes stay readable.
- R7: With overwrite enable at 1, a start of packet that arrives while the count is non-zero discards the stored bytes, opens the new packet and sets the overwrite status (status bit 7).
- R8: With valid-flag enable (configuration bit 0) at 1, the quality flag of the k-th byte of the packet reads as 0x00 or 0x01 at address 0x10+k (k = 0..7). With the mode off, that window reads 0x00.
- R9: When fast-turn (configuration bit 3) is 1 and high/low select (configuration bit 4) is 0, each byte is stored bit-inverted. With any other setting it is stored unchanged.
- R10: Status bits 5, 4 and 3 and the outputs `buf_full_o`, `buf_half_o` and `buf_nempty_o` are live. Full means count equal to capacity. Half-empty means count at most half of capacity. Not-empty means count above 0.
- R11: Status bits 7 (overwrite), 6 (start of packet taken), 2 (buffer error), 1 (packet complete) and 0 (receive error) are sticky. A status read clears them, and an event in the same cycle as the read keeps its bit set.
- R12: `irq_o` is high when any status bit 6..0 is set together with the control enable at the same position, or when status bit 7 is set with overwrite enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sop_i | input | 1 | Start-of-packet strobe |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| byte_ok_i | input | 1 | Quality flag of the received byte |
| eop_i | input | 1 | End-of-packet strobe |
| err_i | input | 1 | Receive error strobe |
| host_wr_i | input | 1 | Host register write |
| host_rd_i | input | 1 | Host register read |
| host_addr_i | input | 5 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Registered host read data |
| rx_busy_o | output | 1 | Receive mode active |
| buf_full_o | output | 1 | Buffer full |
| buf_half_o | output | 1 | Buffer at most half full |
| buf_nempty_o | output | 1 | Buffer not empty |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a start of packet that meets a buffer still holding an unread part of the previous packet, under both overwrite settings. Reaching it takes a full arm, receive, close sequence, a partial drain, and then a second arm. The stimulus builds that sequence in order. It also lines up reads, writes and strobes so that a sticky event lands in the same cycle as a status read. A behavioural model keeps the buffer as a queue and is compared with the outputs on every clock.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h02;
  localparam logic [ADDR_W-1:0] A_CNT  = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATA = 5'h04;
  localparam logic [ADDR_W-1:0] A_FLAG = 5'h10;

  localparam logic [6:0] CTRL_EN_RST = 7'h07;

  localparam int unsigned C_HILO = 4;
  localparam int unsigned C_FAST = 3;
  localparam int unsigned C_OVW  = 1;
  localparam int unsigned C_VFE  = 0;

  typedef struct packed {
    logic hilo;
    logic fast;
    logic ovw;
    logic vfe;
  } cfg_t;

  typedef struct packed {
    logic ovw;
    logic sop;
    logic berr;
    logic done;
    logic rerr;
  } evt_t;
endpackage

// File: rtl/rxbuf_rst_sync.sv
module rxbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/rxbuf_regs.sv
module rxbuf_regs
  import rxbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pkt_end,
  output logic [6:0]        en,
  output logic              rx_active,
  output cfg_t              cfg
);
  logic [6:0] en_q, en_d;
  logic       rx_q, rx_d, rx_ce;
  cfg_t       cfg_q, cfg_d;

  always_comb begin
    en_d  = wdata[6:0];
    rx_ce = (wr_ctrl && wdata[7]) || pkt_end;
    rx_d  = wr_ctrl && wdata[7];
    cfg_d.hilo = wdata[C_HILO];
    cfg_d.fast = wdata[C_FAST];
    cfg_d.ovw  = wdata[C_OVW];
    cfg_d.vfe  = wdata[C_VFE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= CTRL_EN_RST;
      rx_q  <= 1'b0;
      cfg_q <= '{hilo: 1'b1, fast: 1'b0, ovw: 1'b0, vfe: 1'b0};
    end else begin
      if (wr_ctrl) en_q  <= en_d;
      if (rx_ce)   rx_q  <= rx_d;
      if (wr_cfg)  cfg_q <= cfg_d;
    end
  end

  assign en        = en_q;
  assign rx_active = rx_q;
  assign cfg       = cfg_q;
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned HALF = DEPTH / 2,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              ow_en,
  input  logic              vf_en,
  input  logic              inv,
  input  logic              sop,
  input  logic              bvld,
  input  logic [BYTE_W-1:0] bdata,
  input  logic              bok,
  input  logic              eop,
  input  logic              err,
  input  logic              pop,
  input  logic [IDXW-2:0]   flag_idx,
  output logic [BYTE_W-1:0] head,
  output logic [BYTE_W-1:0] flag_rd,
  output logic [CNTW-1:0]   cnt,
  output logic [CNTW-1:0]   cap,
  output logic              open,
  output evt_t              ev,
  output logic              pkt_end
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CNTW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic              open_q, open_d, ptr_ce;
  logic              empty, wr_try, wr_fire, pop_fire;
  logic [BYTE_W-1:0] wdat;
  logic [DEPTH-1:0]  we;
  logic [BYTE_W-1:0] wv [DEPTH];

  always_comb begin
    cap      = vf_en ? CNTW'(HALF) : CNTW'(DEPTH);
    cnt      = wr_q - rd_q;
    empty    = (cnt == '0);
    ev.sop   = sop && rx_active && !open_q && (empty || ow_en);
    ev.ovw   = ev.sop && !empty;
    wr_try   = bvld && open_q;
    wr_fire  = wr_try && (wr_q < cap);
    pop_fire = pop && !empty;
    ev.berr  = (wr_try && !wr_fire) || (pop && empty);
    ev.done  = open_q && eop;
    ev.rerr  = open_q && err;
    pkt_end  = open_q && (eop || err);
    wdat     = bdata ^ {BYTE_W{inv}};
    ptr_ce   = ev.sop || wr_fire || pop_fire;
    wr_d     = ev.sop ? '0 : wr_q + CNTW'(wr_fire);
    rd_d     = ev.sop ? '0 : rd_q + CNTW'(pop_fire);
    open_d   = ev.sop || (open_q && !pkt_end);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_data, hit_flag;
    assign hit_data = wr_fire && (wr_q == CNTW'(i));
    if (i >= HALF) begin : g_hi
      assign hit_flag = wr_fire && vf_en && (wr_q == CNTW'(i - HALF));
    end else begin : g_lo
      assign hit_flag = 1'b0;
    end
    assign we[i] = hit_data || hit_flag;
    assign wv[i] = hit_flag ? {{(BYTE_W-1){1'b0}}, bok} : wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      open_q <= 1'b0;
    end else begin
      if (ptr_ce) begin
        wr_q <= wr_d;
        rd_q <= rd_d;
      end
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) mem[i] <= wv[i];
    end
  end

  assign head    = mem[rd_q[IDXW-1:0]];
  assign flag_rd = mem[{1'b1, flag_idx}];
  assign open    = open_q;
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
  import rxbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              ev,
  input  logic              clr,
  input  logic              full,
  input  logic              half,
  input  logic              nemp,
  input  logic [6:0]        en,
  input  logic              ow_en,
  output logic [BYTE_W-1:0] status,
  output logic              irq
);
  evt_t lat_q, lat_d;

  always_comb begin
    lat_d  = (clr ? '0 : lat_q) | ev;
    status = {lat_q.ovw, lat_q.sop, full, half, nemp, lat_q.berr, lat_q.done, lat_q.rerr};
    irq    = (|(status[6:0] & en)) || (status[7] && ow_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_ok_i,
  input  logic              eop_i,
  input  logic              err_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic              rx_busy_o,
  output logic              buf_full_o,
  output logic              buf_half_o,
  output logic              buf_nempty_o,
  output logic              irq_o
);
  localparam int unsigned IDXW = $clog2(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic              rst_ns;
  logic [6:0]        en;
  logic              rx_active, pkt_end, open;
  cfg_t              cfg;
  evt_t              ev;
  logic [BYTE_W-1:0] head, flag_rd, status, rd_nxt, rdata_q;
  logic [CNTW-1:0]   cnt, cap;
  logic              wr_ctrl, wr_cfg, rd_pop, rd_stat, in_flag;

  assign wr_ctrl = host_wr_i && (host_addr_i == A_CTRL);
  assign wr_cfg  = host_wr_i && (host_addr_i == A_CFG);
  assign rd_pop  = host_rd_i && (host_addr_i == A_DATA);
  assign rd_stat = host_rd_i && (host_addr_i == A_STAT);
  assign in_flag = (host_addr_i[ADDR_W-1:IDXW-1] == A_FLAG[ADDR_W-1:IDXW-1]);

  rxbuf_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  rxbuf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .wr_ctrl   (wr_ctrl),
    .wr_cfg    (wr_cfg),
    .wdata     (host_wdata_i),
    .pkt_end   (pkt_end),
    .en        (en),
    .rx_active (rx_active),
    .cfg       (cfg)
  );

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_ns),
    .rx_active (rx_active),
    .ow_en     (cfg.ovw),
    .vf_en     (cfg.vfe),
    .inv       (cfg.fast && !cfg.hilo),
    .sop       (sop_i),
    .bvld      (byte_vld_i),
    .bdata     (byte_i),
    .bok       (byte_ok_i),
    .eop       (eop_i),
    .err       (err_i),
    .pop       (rd_pop),
    .flag_idx  (host_addr_i[IDXW-2:0]),
    .head      (head),
    .flag_rd   (flag_rd),
    .cnt       (cnt),
    .cap       (cap),
    .open      (open),
    .ev        (ev),
    .pkt_end   (pkt_end)
  );

  assign buf_full_o   = (cnt == cap);
  assign buf_half_o   = (cnt <= (cap >> 1));
  assign buf_nempty_o = (cnt != '0);

  rxbuf_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_ns),
    .ev     (ev),
    .clr    (rd_stat),
    .full   (buf_full_o),
    .half   (buf_half_o),
    .nemp   (buf_nempty_o),
    .en     (en),
    .ow_en  (cfg.ovw),
    .status (status),
    .irq    (irq_o)
  );

  always_comb begin
    rd_nxt = '0;
    if (host_addr_i == A_CTRL) begin
      rd_nxt = {rx_active, en};
    end else if (host_addr_i == A_CFG) begin
      rd_nxt[C_HILO] = cfg.hilo;
      rd_nxt[C_FAST] = cfg.fast;
      rd_nxt[C_OVW]  = cfg.ovw;
      rd_nxt[C_VFE]  = cfg.vfe;
    end else if (host_addr_i == A_STAT) begin
      rd_nxt = status;
    end else if (host_addr_i == A_CNT) begin
      rd_nxt[CNTW-1:0] = cnt;
    end else if (host_addr_i == A_DATA) begin
      rd_nxt = buf_nempty_o ? head : '0;
    end else if (in_flag) begin
      rd_nxt = cfg.vfe ? flag_rd : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)        rdata_q <= '0;
    else if (host_rd_i) rdata_q <= rd_nxt;
  end

  assign host_rdata_o = rdata_q;
  assign rx_busy_o    = rx_active;
endmodule

// File: rtl/rxbuf_ctrl_chk.sv
module rxbuf_ctrl_chk
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              sop_i,
  input logic              byte_vld_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [BYTE_W-1:0] host_wdata_i,
  input logic [BYTE_W-1:0] host_rdata_o,
  input logic              rx_busy_o,
  input logic              irq_o,
  input logic [CNTW-1:0]   cnt,
  input logic [CNTW-1:0]   cap,
  input logic              open,
  input logic [6:0]        en,
  input logic              ow_en,
  input logic [BYTE_W-1:0] status
);
  logic data_rd;
  assign data_rd = host_rd_i && (host_addr_i == A_DATA);

  // R2: without a start write, receive mode cannot rise
  p_go_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rx_busy_o && !(host_wr_i && host_addr_i == A_CTRL && host_wdata_i[7])) |=> !rx_busy_o);

  // R4: a data read on an empty buffer returns zero
  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (data_rd && cnt == '0) |=> (host_rdata_o == '0));

  // R5: a byte beyond capacity leaves the count unchanged
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (byte_vld_i && open && cnt == cap && !data_rd) |=> (cnt == $past(cnt)));

  // R6: refused start of packet keeps the stored bytes
  p_sop_refused_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (sop_i && !ow_en && !open && cnt != '0 && !data_rd) |=> (cnt == $past(cnt)));

  // R7: overwrite empties the buffer and flags it
  p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (sop_i && ow_en && rx_busy_o && !open && cnt != '0) |=> (cnt == '0 && status[7]));

  // R12: no enable means no interrupt
  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    (en == '0 && !ow_en) |-> !irq_o);
endmodule

bind rxbuf_ctrl rxbuf_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .sop_i        (sop_i),
  .byte_vld_i   (byte_vld_i),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .rx_busy_o    (rx_busy_o),
  .irq_o        (irq_o),
  .cnt          (cnt),
  .cap          (cap),
  .open         (open),
  .en           (en),
  .ow_en        (cfg.ovw),
  .status       (status)
);

// File: tb/rxbuf_ctrl_test.sv
module rxbuf_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sop_i = 0, byte_vld_i = 0, byte_ok_i = 0, eop_i = 0, err_i = 0;
  logic [7:0] byte_i = 0;
  logic       host_wr_i = 0, host_rd_i = 0;
  logic [4:0] host_addr_i = 0;
  logic [7:0] host_wdata_i = 0;
  logic [7:0] host_rdata_o;
  logic       rx_busy_o, buf_full_o, buf_half_o, buf_nempty_o, irq_o;

  always #10 clk = ~clk;

  rxbuf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .byte_ok_i(byte_ok_i), .eop_i(eop_i), .err_i(err_i), .host_wr_i(host_wr_i),
    .host_rd_i(host_rd_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .rx_busy_o(rx_busy_o), .buf_full_o(buf_full_o),
    .buf_half_o(buf_half_o), .buf_nempty_o(buf_nempty_o), .irq_o(irq_o)
  );

  int    n_vec = 0, n_bad = 0;
  string req = "R1";

  // reference model state
  bit [6:0] m_en = 7'h07;
  bit       m_rx = 0, m_open = 0;
  bit       m_hilo = 1, m_fast = 0, m_ow = 0, m_vf = 0;
  bit [7:0] m_q[$];
  bit       m_fl[8];
  int       m_wc = 0;
  bit [4:0] m_lat = 0;   // ovw, sop, berr, done, rerr
  bit [7:0] m_rdata = 0;
  bit       m_rd = 0;

  function automatic int m_cap();
    return m_vf ? 8 : 16;
  endfunction

  function automatic bit [7:0] m_status();
    int c = m_q.size();
    return {m_lat[4], m_lat[3], c == m_cap(), c <= m_cap() / 2, c != 0, m_lat[2:0]};
  endfunction

  function automatic bit [7:0] m_read(bit [4:0] a);
    if (a == 5'h00) return {m_rx, m_en};
    if (a == 5'h01) return {3'b0, m_hilo, m_fast, 1'b0, m_ow, m_vf};
    if (a == 5'h02) return m_status();
    if (a == 5'h03) return 8'(m_q.size());
    if (a == 5'h04) return (m_q.size() != 0) ? m_q[0] : 8'h00;
    if (a >= 5'h10 && a <= 5'h17) return m_vf ? {7'b0, m_fl[a - 5'h10]} : 8'h00;
    return 8'h00;
  endfunction

  task automatic m_update();
    int  c = m_q.size();
    bit  clr, acc, ovw, berr = 0, done, rerr;
    bit  inv = m_fast && !m_hilo;
    m_rd = host_rd_i;
    if (host_rd_i) m_rdata = m_read(host_addr_i);
    clr = host_rd_i && host_addr_i == 5'h02;
    acc = sop_i && m_rx && !m_open && (c == 0 || m_ow);
    ovw = acc && c != 0;
    if (host_rd_i && host_addr_i == 5'h04) begin
      if (c == 0) berr = 1; else void'(m_q.pop_front());
    end
    if (byte_vld_i && m_open) begin
      if (m_wc >= m_cap()) berr = 1;
      else begin
        m_q.push_back(inv ? ~byte_i : byte_i);
        if (m_vf) m_fl[m_wc] = byte_ok_i;
        m_wc++;
      end
    end
    done = m_open && eop_i;
    rerr = m_open && err_i;
    if (done || rerr) begin m_open = 0; m_rx = 0; end
    if (acc) begin m_q.delete(); m_wc = 0; m_open = 1; end
    if (host_wr_i && host_addr_i == 5'h00) begin
      m_en = host_wdata_i[6:0];
      if (host_wdata_i[7]) m_rx = 1;
    end
    if (host_wr_i && host_addr_i == 5'h01) begin
      m_hilo = host_wdata_i[4]; m_fast = host_wdata_i[3];
      m_ow = host_wdata_i[1];   m_vf = host_wdata_i[0];
    end
    m_lat = (clr ? 5'b0 : m_lat) | {ovw, acc, berr, done, rerr};
  endtask

  task automatic cmp(string what, int got, int exp, string r);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", r, what, got, exp, $time);
    end
  endtask

  task automatic step();
    bit [7:0] st;
    m_update();
    @(posedge clk);
    @(negedge clk);
    st = m_status();
    cmp("irq_o", irq_o, (|(st[6:0] & m_en)) | (st[7] & m_ow), "R12");
    cmp("buf_full_o", buf_full_o, st[5], "R10");
    cmp("buf_half_o", buf_half_o, st[4], "R10");
    cmp("buf_nempty_o", buf_nempty_o, st[3], "R10");
    cmp("rx_busy_o", rx_busy_o, m_rx, "R2");
    if (m_rd) cmp("host_rdata_o", host_rdata_o, m_rdata, req);
    sop_i = 0; byte_vld_i = 0; eop_i = 0; err_i = 0;
    host_wr_i = 0; host_rd_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic wr(bit [4:0] a, bit [7:0] d);
    host_wr_i = 1; host_addr_i = a; host_wdata_i = d; step();
  endtask
  task automatic rd(bit [4:0] a);
    host_rd_i = 1; host_addr_i = a; step();
  endtask
  task automatic rxb(bit [7:0] d, bit ok);
    byte_vld_i = 1; byte_i = d; byte_ok_i = ok; step();
  endtask
  task automatic sop();  sop_i = 1; step(); endtask
  task automatic eop();  eop_i = 1; step(); endtask
  task automatic drain(int n);
    for (int i = 0; i < n; i++) rd(5'h04);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    req = "R1";  // reset values
    rd(5'h00); rd(5'h01); rd(5'h02); rd(5'h03);

    req = "R3";  // strobes outside receive mode are ignored
    rxb(8'h55, 1); sop(); rxb(8'h66, 1); eop(); rd(5'h03);

    req = "R2";  // arm, write of 0 to bit 7 is no-op
    wr(5'h00, 8'h87); rd(5'h00); wr(5'h00, 8'h07); rd(5'h00);

    req = "R3";  // packet of five bytes
    sop();
    for (int i = 0; i < 5; i++) rxb(8'h11 * (i + 1), 1);
    eop(); rd(5'h00); rd(5'h03);
    req = "R11"; rd(5'h02); rd(5'h02);

    req = "R4";  // drain in order, one read too many
    drain(6); rd(5'h02);

    req = "R6";  // overwrite off: second packet refused
    wr(5'h00, 8'h87); sop(); rxb(8'hA1, 1); rxb(8'hA2, 1); rxb(8'hA3, 1); eop();
    rd(5'h04);
    wr(5'h00, 8'h87); sop(); rxb(8'hB1, 1); eop(); rd(5'h03);
    drain(2); rd(5'h03);
    sop(); rxb(8'hC1, 1); rxb(8'hC2, 1); eop(); rd(5'h03); drain(1);

    req = "R7";  // overwrite on, one byte still unread
    wr(5'h01, 8'h12); wr(5'h00, 8'h87); sop(); rxb(8'hD1, 1); eop();
    rd(5'h03); rd(5'h02); drain(2);

    req = "R11"; // event in the same cycle as the status read
    wr(5'h00, 8'h87); host_rd_i = 1; host_addr_i = 5'h02; sop_i = 1; step();
    rd(5'h02); eop();

    req = "R5";  // overflow in normal mode
    wr(5'h01, 8'h10); wr(5'h00, 8'h87); sop();
    for (int i = 0; i < 18; i++) rxb(8'(i + 8'h20), 1);
    eop(); rd(5'h03); rd(5'h02); drain(16); rd(5'h03);

    req = "R8";  // valid-flag mode
    wr(5'h01, 8'h11); wr(5'h00, 8'h87); sop();
    for (int i = 0; i < 10; i++) rxb(8'(i + 8'h40), (i % 3) != 0);
    eop(); rd(5'h03); rd(5'h02);
    for (int k = 0; k < 8; k++) rd(5'(8'h10 + k));
    drain(8);
    wr(5'h01, 8'h10); rd(5'h10); rd(5'h13);

    req = "R9";  // inversion only with fast turn and low select
    wr(5'h01, 8'h08); wr(5'h00, 8'h87); sop(); rxb(8'h0F, 1); rxb(8'hA5, 1); eop();
    drain(2);
    wr(5'h01, 8'h18); wr(5'h00, 8'h87); sop(); rxb(8'h0F, 1); eop(); drain(1);

    req = "R3";  // error strobe ends the packet
    wr(5'h01, 8'h10); wr(5'h00, 8'h87); sop(); rxb(8'h77, 1); err_i = 1; step();
    rd(5'h00); rxb(8'h78, 1); rd(5'h03); rd(5'h02);

    req = "R12"; // enables walk over live and sticky status
    wr(5'h00, 8'h7F); idle(2); rd(5'h02); wr(5'h00, 8'h08); idle(2);
    wr(5'h00, 8'h10); idle(2); drain(1); wr(5'h00, 8'h00); rd(5'h04); idle(2);
    req = "R10"; rd(5'h02); wr(5'h00, 8'h07); idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule